// File: doc/BRIEF.md
# Stereo Converter Offset Calibration Controller

This block sits on the digital side of a two-channel audio converter. It sits between the decimated sample stream and the serial output stage. When a calibration is requested, it enters a calibration cycle. Reset, or the release of power-down, counts as such a request. During the cycle it averages a fixed number of frames of each channel into a per-channel offset word.

A source-select input chooses what is averaged during the cycle. It can be the normal input path or a zero-reference path. If the busy output is wired back to the select, the zero path is measured automatically. Throughout the cycle both outputs are blanked to a signed zero. Afterwards every sample has its channel's stored offset removed, and the result is clamped to the signed range rather than wrapping.

A settling flag follows each cycle. It marks the frames in which the downstream filter has not yet recovered. Samples move one frame strobe at a time, and each output is registered one clock after its strobe.

Top module: `stereo_offset_cal`

## Requirements
- R1: A synchronous reset clears both offsets to zero, drives both outputs to zero and leaves busy and settling low. The first frame strobe after reset starts a calibration cycle, so busy is high after that strobe.
- R2: Once started, busy stays high for exactly 2^CAL_LOG2 frame strobes (4096 by default) and drops right after the last of them.
- R3: Every frame strobe taken while busy is high produces an output word of zero on both channels.
- R4: At the end of a cycle each channel's offset becomes the floor of the mean of the samples it took during the cycle. The floor is the sum shifted right arithmetically by CAL_LOG2. Each channel is computed independently of the other.
- R5: Outside a cycle, each output equals that channel's input minus that channel's stored offset.
- R6: When the difference in R5 leaves the signed SAMPLE_W range, the output clamps to the most positive or most negative code.
- R7: During a cycle, zero_sel low averages left_in/right_in and zero_sel high averages left_zref/right_zref. The value is taken at each strobe.
- R8: Settling goes high when busy falls. It stays high for exactly SETTLE_FRAMES frame strobes (40 by default), then returns low.
- R9: A cal_req raised while busy is high is ignored: the cycle neither restarts nor lengthens.
- R10: A cal_req raised while busy is low arms a new cycle. Busy does not rise until the next frame strobe, which starts the cycle.
- R11: out_stb pulses high for one clock exactly one clock after each frame strobe. Between strobes, the output words hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-clock strobe per stereo frame |
| left_in | input | SAMPLE_W | Left sample, normal path, two's complement |
| right_in | input | SAMPLE_W | Right sample, normal path, two's complement |
| left_zref | input | SAMPLE_W | Left sample, zero-reference path |
| right_zref | input | SAMPLE_W | Right sample, zero-reference path |
| zero_sel | input | 1 | Source used during calibration: 0 normal, 1 zero reference |
| cal_req | input | 1 | Request a calibration cycle |
| left_out | output | SAMPLE_W | Corrected left sample |
| right_out | output | SAMPLE_W | Corrected right sample |
| out_stb | output | 1 | Output words updated this clock |
| cal_busy | output | 1 | Calibration cycle in progress |
| settling | output | 1 | Post-calibration settling interval |

## Verification
A frame counter that is off by one would show up on busy as a cycle one strobe long or short. It would also shift the settling interval, and both can be seen at the end of the first calibration, about 4100 frames after reset. A wrong accumulator or mean would not be visible during the cycle, because the outputs are blanked then. It would show as a constant error on the first corrected output word, one clock after the first strobe following busy. Wrong saturation or a wrong source selection appears the same way, on the first frame after the cycle in which the offending data was averaged.

// File: rtl/stereo_cal_pkg.sv
package stereo_cal_pkg;
  typedef enum logic [1:0] {
    ST_ARM    = 2'd0,
    ST_CAL    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } cal_state_e;
endpackage

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int CAL_LOG2      = 12,
  parameter int SETTLE_FRAMES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic cal_req,
  output logic busy,
  output logic settling,
  output logic acc_clear,
  output logic acc_en,
  output logic acc_last
);
  import stereo_cal_pkg::*;
  localparam int SET_W = $clog2(SETTLE_FRAMES + 1);

  cal_state_e          state_q;
  logic [CAL_LOG2-1:0] cal_cnt_q;
  logic [SET_W-1:0]    set_cnt_q;
  logic                settle_done;

  assign busy        = (state_q == ST_CAL);
  assign settling    = (state_q == ST_SETTLE);
  assign acc_clear   = frame_stb && (state_q == ST_ARM);
  assign acc_en      = frame_stb && busy;
  assign acc_last    = acc_en && (cal_cnt_q == '1);
  assign settle_done = (set_cnt_q == SET_W'(SETTLE_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ARM;
      cal_cnt_q <= '0;
      set_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_ARM: begin
          if (frame_stb) begin
            state_q   <= ST_CAL;
            cal_cnt_q <= '0;
          end
        end
        ST_CAL: begin
          if (frame_stb) begin
            cal_cnt_q <= cal_cnt_q + 1'b1;
            if (cal_cnt_q == '1) begin
              state_q   <= ST_SETTLE;
              set_cnt_q <= '0;
            end
          end
        end
        ST_SETTLE: begin
          if (cal_req) begin
            state_q <= ST_ARM;
          end else if (frame_stb) begin
            if (settle_done) state_q <= ST_RUN;
            else             set_cnt_q <= set_cnt_q + 1'b1;
          end
        end
        default: begin
          if (cal_req) state_q <= ST_ARM;
        end
      endcase
    end
  end

  // R2: busy only falls right after the final counted strobe
  a_r2_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(acc_last));
  // R9: a request inside the cycle does not end or restart it
  a_r9_req_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && cal_req && !acc_last) |=> busy);
  // R8: settling takes over the moment busy drops
  a_r8_settle_follows: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> settling);
  // R1: busy is low on the first cycle after reset release
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !busy);
  // R10: busy only rises on a frame strobe
  a_r10_start_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frame_stb));
endmodule

// File: rtl/offset_estimator.sv
module offset_estimator #(
  parameter int SAMPLE_W = 24,
  parameter int CAL_LOG2 = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_clear,
  input  logic                       acc_en,
  input  logic                       acc_last,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [SAMPLE_W-1:0] offset
);
  localparam int ACC_W = SAMPLE_W + CAL_LOG2;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_next;

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [SAMPLE_W-1:0] v);
    return {{CAL_LOG2{v[SAMPLE_W-1]}}, v};
  endfunction

  // floor of sum / 2^CAL_LOG2 (arithmetic shift, then keep the sample width)
  function automatic logic signed [SAMPLE_W-1:0] mean_of(input logic signed [ACC_W-1:0] s);
    return s[ACC_W-1:CAL_LOG2];
  endfunction

  assign acc_next = acc_q + widen(sample);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      offset <= '0;
    end else if (acc_clear) begin
      acc_q <= '0;
    end else if (acc_en) begin
      if (acc_last) begin
        offset <= mean_of(acc_next);
        acc_q  <= '0;
      end else begin
        acc_q <= acc_next;
      end
    end
  end

  // R4: the offset only moves at the end of a calibration cycle
  a_r4_offset_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_last |=> $stable(offset));
endmodule

// File: rtl/offset_corrector.sv
module offset_corrector #(
  parameter int SAMPLE_W = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_stb,
  input  logic                       blank,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] offset,
  output logic signed [SAMPLE_W-1:0] result
);
  localparam logic signed [SAMPLE_W-1:0] MAX_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};

  function automatic logic signed [SAMPLE_W-1:0] sat_sub(
    input logic signed [SAMPLE_W-1:0] a,
    input logic signed [SAMPLE_W-1:0] b);
    logic signed [SAMPLE_W:0] d;
    d = {a[SAMPLE_W-1], a} - {b[SAMPLE_W-1], b};
    if (d[SAMPLE_W] != d[SAMPLE_W-1]) return d[SAMPLE_W] ? MIN_V : MAX_V;
    return d[SAMPLE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst)            result <= '0;
    else if (frame_stb) result <= blank ? '0 : sat_sub(sample, offset);
  end

  // R3: blanked frames come out as zero
  a_r3_blank_zero: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && blank) |=> (result == '0));
  // R5: with no offset stored the sample passes unchanged
  a_r5_zero_offset_pass: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !blank && offset == '0) |=> (result == $past(sample)));
  // R11: no strobe, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(result));
endmodule

// File: rtl/stereo_offset_cal.sv
module stereo_offset_cal #(
  parameter int SAMPLE_W      = 24,
  parameter int CAL_LOG2      = 12,
  parameter int SETTLE_FRAMES = 40
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_stb,
  input  logic signed [SAMPLE_W-1:0] left_in,
  input  logic signed [SAMPLE_W-1:0] right_in,
  input  logic signed [SAMPLE_W-1:0] left_zref,
  input  logic signed [SAMPLE_W-1:0] right_zref,
  input  logic                       zero_sel,
  input  logic                       cal_req,
  output logic signed [SAMPLE_W-1:0] left_out,
  output logic signed [SAMPLE_W-1:0] right_out,
  output logic                       out_stb,
  output logic                       cal_busy,
  output logic                       settling
);
  localparam int NCH = 2;

  logic acc_clear, acc_en, acc_last;
  logic signed [SAMPLE_W-1:0] ch_in   [NCH];
  logic signed [SAMPLE_W-1:0] ch_zref [NCH];
  logic signed [SAMPLE_W-1:0] ch_meas [NCH];
  logic signed [SAMPLE_W-1:0] ch_off  [NCH];
  logic signed [SAMPLE_W-1:0] ch_out  [NCH];

  assign ch_in[0]   = left_in;
  assign ch_in[1]   = right_in;
  assign ch_zref[0] = left_zref;
  assign ch_zref[1] = right_zref;
  assign left_out   = ch_out[0];
  assign right_out  = ch_out[1];

  cal_sequencer #(.CAL_LOG2(CAL_LOG2), .SETTLE_FRAMES(SETTLE_FRAMES)) seq_i (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .cal_req(cal_req),
    .busy(cal_busy), .settling(settling),
    .acc_clear(acc_clear), .acc_en(acc_en), .acc_last(acc_last));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_meas[c] = zero_sel ? ch_zref[c] : ch_in[c];

    offset_estimator #(.SAMPLE_W(SAMPLE_W), .CAL_LOG2(CAL_LOG2)) est_i (
      .clk(clk), .rst(rst), .acc_clear(acc_clear), .acc_en(acc_en),
      .acc_last(acc_last), .sample(ch_meas[c]), .offset(ch_off[c]));

    offset_corrector #(.SAMPLE_W(SAMPLE_W)) cor_i (
      .clk(clk), .rst(rst), .frame_stb(frame_stb), .blank(cal_busy),
      .sample(ch_in[c]), .offset(ch_off[c]), .result(ch_out[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) out_stb <= 1'b0;
    else     out_stb <= frame_stb;
  end

  // R11: output strobe follows the frame strobe by one clock
  a_r11_stb_delay: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> out_stb);
  a_r11_stb_single: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> !out_stb);
endmodule

// File: tb/stereo_offset_cal_tb.sv
module stereo_offset_cal_tb_top;
  localparam int W = 24;
  localparam int LOG = 12;
  localparam int NCAL = 1 << LOG;
  localparam int SETTLE = 40;
  localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic signed [W-1:0] left_in = '0, right_in = '0, left_zref = '0, right_zref = '0;
  logic cal_req = 1'b0;
  logic tie_sel = 1'b0;
  logic zero_sel;
  logic signed [W-1:0] left_out, right_out;
  logic out_stb, cal_busy, settling;

  int n_tests = 0;
  int n_fail = 0;
  longint off_l = 0, off_r = 0;

  always #5 clk = ~clk;
  assign zero_sel = tie_sel ? cal_busy : 1'b0;

  stereo_offset_cal #(.SAMPLE_W(W), .CAL_LOG2(LOG), .SETTLE_FRAMES(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .frame_stb(frame_stb),
    .left_in(left_in), .right_in(right_in), .left_zref(left_zref), .right_zref(right_zref),
    .zero_sel(zero_sel), .cal_req(cal_req),
    .left_out(left_out), .right_out(right_out), .out_stb(out_stb),
    .cal_busy(cal_busy), .settling(settling));

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat_model(input longint a, input longint b);
    longint d = a - b;
    if (d > MAXV) return MAXV;
    if (d < MINV) return MINV;
    return d;
  endfunction

  // one frame strobe; outputs are valid on return
  task automatic frame(input longint l, input longint r, input longint zl, input longint zr,
                       input bit req);
    @(negedge clk);
    frame_stb = 1'b1; cal_req = req;
    left_in = W'(l); right_in = W'(r); left_zref = W'(zl); right_zref = W'(zr);
    @(negedge clk);
    frame_stb = 1'b0; cal_req = 1'b0;
  endtask

  // starts from an armed state, runs a full cycle and checks it
  task automatic run_cal(input bit use_zref, input longint base_l, input longint base_r,
                         input int req_at);
    longint sum_l = 0, sum_r = 0;
    int n = 0;
    frame(5, -5, 0, 0, 1'b0);
    chk("R10 busy after arming strobe", cal_busy, 1);
    while (cal_busy && n < NCAL + 50) begin
      longint pl = base_l + (n % 9) - 4 + ((n % 3 == 0) ? 1 : 0);
      longint pr = base_r - (n % 7) + 2;
      longint gl = 12345 - n, gr = -777 + n;
      if (use_zref) frame(gl, gr, pl, pr, n == req_at);
      else          frame(pl, pr, gl, gr, n == req_at);
      sum_l += pl; sum_r += pr;
      n++;
      if (left_out != 0 || right_out != 0)
        chk("R3 blank during cal", {left_out, right_out}, 0);
    end
    chk("R3 blanked frames seen", n, NCAL);
    chk("R2 busy length in strobes (R9 mid-cycle request ignored)", n, NCAL);
    chk("R8 settling high after busy falls", settling, 1);
    off_l = sum_l >>> LOG;
    off_r = sum_r >>> LOG;
  endtask

  task automatic t_reset();
    chk("R1 left out zero at reset", left_out, 0);
    chk("R1 right out zero at reset", right_out, 0);
    chk("R1 busy low after reset", cal_busy, 0);
    chk("R1 settling low after reset", settling, 0);
  endtask

  task automatic t_first_cal();
    tie_sel = 1'b1;
    run_cal(1'b1, -1003, 2471, -1);
    tie_sel = 1'b0;
  endtask

  task automatic t_correct();
    int i;
    for (i = 1; i <= SETTLE; i++) begin
      longint l = 1000 * i - 20000, r = 3000 - 77 * i;
      frame(l, r, 0, 0, 1'b0);
      if (i == 1) chk("R11 out_stb one clock after strobe", out_stb, 1);
      chk("R4 R5 left corrected (zero-ref offset)", left_out, l - off_l);
      chk("R4 R5 right corrected (zero-ref offset)", right_out, r - off_r);
      chk("R8 settling count", settling, (i < SETTLE) ? 1 : 0);
    end
    @(negedge clk);
    chk("R11 out_stb single clock", out_stb, 0);
    chk("R11 output held between strobes", right_out, (3000 - 77 * SETTLE) - off_r);
  endtask

  task automatic t_sat_cal();
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0;
    chk("R10 busy waits for strobe", cal_busy, 0);
    run_cal(1'b0, 64'sd4194304, -64'sd4194304, 100);
    frame(MINV, MAXV, 0, 0, 1'b0);
    chk("R7 R4 normal-path offset left", left_out, sat_model(MINV, off_l));
    chk("R6 negative clamp", left_out, MINV);
    chk("R6 positive clamp", right_out, MAXV);
    frame(100, -100, 0, 0, 1'b0);
    chk("R5 R7 left after normal-path cal", left_out, sat_model(100, off_l));
    chk("R5 R7 right after normal-path cal", right_out, sat_model(-100, off_r));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_cal();
    t_correct();
    t_sat_cal();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule